// File: doc/BRIEF.md
# PHY power-up calibration sequencer

This block is a hardware state machine that brings the analog front end of a storage-interface PHY up or down in a fixed order. A single-cycle request selects power-on or power-off and carries the card-clock rate in Hz, as measured elsewhere. The block drives the power-up control, the DLL-enable control and a 2-bit DLL frequency band. It waits on a calibration-done input and a DLL-ready input, and each wait has its own timeout. When the sequence ends it gives a one-cycle completion pulse with a sticky error code and an unsupported-rate flag.

All waits are counted in microseconds. A prescaler built from the `CYC_PER_US` parameter derives them from the system clock. The frequency band and the rate flag come from the rate captured when the request was accepted. The rate input may change freely while a sequence runs.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset `pwr_up_o`, `dll_en_o`, `done_o`, `busy_o` and `rate_warn_o` are 0, `freq_sel_o` is 0 and `err_o` is 0 (no error).
- R2: An accepted request of either kind drives `pwr_up_o` and `dll_en_o` low in the cycle after acceptance. A power-off request (`req_on`=0) completes there: `done_o` pulses in that same cycle, `busy_o` stays 0 and `err_o` is 0.
- R3: For power-on, both controls stay low for at least `SETTLE_US` microseconds (`SETTLE_US*CYC_PER_US` cycles) and at most two cycles more before `pwr_up_o` rises.
- R4: If `cal_done_i` does not arrive within `CAL_TMO_US` microseconds of `pwr_up_o` rising, the sequence ends with `err_o`=1. At that point `pwr_up_o` stays 1, `dll_en_o` stays 0 and `done_o` pulses.
- R5: `freq_sel_o` is 1 for 1..74,999,999 Hz, 2 for 75,000,000..124,999,999 Hz, 3 for 125,000,000..174,999,999 Hz, and 0 for 175,000,000 Hz and above and for 0 Hz.
- R6: `freq_sel_o` is loaded only after `cal_done_i` has been seen, and at least one cycle before `dll_en_o` rises. `dll_en_o` is never high while `pwr_up_o` is low.
- R7: With a latched rate of 0 the DLL is still enabled, and `done_o` pulses in the cycle in which `dll_en_o` rises, without waiting for `dll_ready_i`.
- R8: For a nonzero rate, if `dll_ready_i` does not arrive within `DLL_TMO_US` microseconds of the DLL being enabled, the sequence ends with `err_o`=2 and a `done_o` pulse.
- R9: `rate_warn_o` is set for a power-on when the rate is above 200 MHz. It is also set when the rate is above 50 MHz and lies more than 15 MHz from its band's nominal rate, which is 50, 100, 150 or 200 MHz for codes 1, 2, 3 and 0.
- R10: `req_valid` has no effect while `busy_o` is 1. A power-off pulse during a power-on sequence neither lowers the controls nor changes the result.
- R11: The rate is captured at acceptance. Changes on `rate_hz` afterwards do not affect `freq_sel_o` or `rate_warn_o`.
- R12: `done_o` lasts one cycle. `err_o` holds its value until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_on | input | 1 | 1 = power-on, 0 = power-off |
| rate_hz | input | RATE_W | Measured card-clock rate in Hz |
| cal_done_i | input | 1 | Calibration finished |
| dll_ready_i | input | 1 | DLL locked |
| pwr_up_o | output | 1 | Analog power-up control |
| dll_en_o | output | 1 | DLL enable control |
| freq_sel_o | output | 2 | DLL frequency band |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Sticky result: 0 none, 1 calibration timeout, 2 DLL lock timeout |
| rate_warn_o | output | 1 | Unsupported-rate flag for the last power-on |

## Verification
The in-design properties assume that reset is applied before the first request and that the status inputs are plain two-state levels. They do not assume any bound on how long calibration or lock may take, because the block's own timeouts cover that. The stimulus raises `cal_done_i` and `dll_ready_i` only after the sequence has reached the matching wait, drops them once `done_o` has pulsed, and sends new requests only after completion, apart from deliberate power-off pulses while busy. Random rates span 0 to 260 MHz and are mixed with directed rates at each band edge and each warning threshold. Random response delays stay inside the timeout windows, and separate directed runs leave each status input low so that both timeouts fire.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CAL_WAIT,
      ST_DLL_ON,
      ST_LOCK_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_CAL_TMO  = 2'd1,
      ERR_LOCK_TMO = 2'd2
   } seq_err_t;

endpackage

// File: rtl/phy_rate_band.sv
// Maps a clock rate onto one of four DLL bands and flags rates far from a band centre.
module phy_rate_band #(
   parameter int unsigned RATE_W  = 32,
   parameter int unsigned STEP_HZ = 50_000_000,
   parameter int unsigned TOL_HZ  = 15_000_000
) (
   input  logic [RATE_W-1:0] rate,
   output logic [1:0]        band,
   output logic              warn
);
   localparam logic [63:0] STEP = 64'(STEP_HZ);
   localparam logic [63:0] TOL  = 64'(TOL_HZ);
   localparam logic [63:0] TOP  = 64'd4 * STEP;

   if (RATE_W < 8 || RATE_W > 63) begin : g_bad_width
      $error("phy_rate_band: RATE_W out of range");
   end
   if (STEP_HZ == 0 || TOL_HZ >= STEP_HZ) begin : g_bad_step
      $error("phy_rate_band: STEP_HZ/TOL_HZ inconsistent");
   end

   logic [63:0] r, nom, diff;

   always_comb begin
      r    = 64'(rate);
      band = 2'd0;
      nom  = TOP;
      // walk bands downwards so the lowest matching band wins
      for (int k = 3; k >= 1; k--) begin
         if (r < ((64'(2 * k + 1) * STEP) >> 1)) begin
            band = 2'(k);
            nom  = 64'(k) * STEP;
         end
      end
      if (r == 64'd0) begin
         band = 2'd0;
         nom  = TOP;
      end
      diff = (r > nom) ? (r - nom) : (nom - r);
      warn = ((r > STEP) && (diff > TOL)) || (r > TOP);
   end

   // R5: a nonzero band code is only produced below the top nominal rate
   always_comb begin
      a_band_below_top_r5: assert (band == 2'd0 || r < TOP);
   end

endmodule

// File: rtl/phy_us_timer.sv
// Microsecond counter with a cycle prescaler; restarts on clr.
module phy_us_timer #(
   parameter int unsigned CYC_PER_US = 50,
   parameter int unsigned LIM_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LIM_W-1:0] limit_us,
   output logic             expired
);
   localparam int unsigned PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

   if (CYC_PER_US < 1) begin : g_bad_cyc
      $error("phy_us_timer: CYC_PER_US must be at least 1");
   end

   logic             tick;
   logic [LIM_W-1:0] us_q;

   if (CYC_PER_US == 1) begin : g_no_pre
      assign tick = 1'b1;
   end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           pre_q <= '0;
         else if (clr)                         pre_q <= '0;
         else if (pre_q == PRE_W'(CYC_PER_US - 1)) pre_q <= '0;
         else                                  pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(CYC_PER_US - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     us_q <= '0;
      else if (clr)                   us_q <= '0;
      else if (tick && (us_q != '1))  us_q <= us_q + 1'b1;
   end

   assign expired = (us_q >= limit_us);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
   import phy_seq_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 50,
   parameter int unsigned RATE_W     = 32,
   parameter int unsigned SETTLE_US  = 3,
   parameter int unsigned CAL_TMO_US = 50,
   parameter int unsigned DLL_TMO_US = 50_000,
   parameter int unsigned STEP_HZ    = 50_000_000,
   parameter int unsigned TOL_HZ     = 15_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_on,
   input  logic [RATE_W-1:0] rate_hz,
   input  logic              cal_done_i,
   input  logic              dll_ready_i,
   output logic              pwr_up_o,
   output logic              dll_en_o,
   output logic [1:0]        freq_sel_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        err_o,
   output logic              rate_warn_o
);
   localparam int unsigned LIM_A   = (SETTLE_US > CAL_TMO_US) ? SETTLE_US : CAL_TMO_US;
   localparam int unsigned LIM_MAX = (LIM_A > DLL_TMO_US) ? LIM_A : DLL_TMO_US;
   localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);

   if (SETTLE_US == 0 || CAL_TMO_US == 0 || DLL_TMO_US == 0) begin : g_bad_wait
      $error("phy_pwr_seq: every wait must be at least one microsecond");
   end

   seq_state_t        state_q;
   seq_err_t          err_q;
   logic [RATE_W-1:0] rate_q;
   logic              pwr_q, dll_q, done_q, warn_q;
   logic [1:0]        freq_q;
   logic [1:0]        band_c;
   logic              warn_c;
   logic              tmr_clr, tmr_exp;
   logic [LIM_W-1:0]  tmr_lim;

   phy_rate_band #(
      .RATE_W (RATE_W),
      .STEP_HZ(STEP_HZ),
      .TOL_HZ (TOL_HZ)
   ) u_band (
      .rate(rate_q),
      .band(band_c),
      .warn(warn_c)
   );

   // timer restarts in the states that precede each timed wait
   always_comb begin
      tmr_clr = (state_q == ST_IDLE) || (state_q == ST_DLL_ON) ||
                ((state_q == ST_SETTLE) && tmr_exp);
      case (state_q)
         ST_SETTLE:   tmr_lim = LIM_W'(SETTLE_US);
         ST_CAL_WAIT: tmr_lim = LIM_W'(CAL_TMO_US);
         default:     tmr_lim = LIM_W'(DLL_TMO_US);
      endcase
   end

   phy_us_timer #(
      .CYC_PER_US(CYC_PER_US),
      .LIM_W     (LIM_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .limit_us(tmr_lim),
      .expired (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= ERR_NONE;
         rate_q  <= '0;
         pwr_q   <= 1'b0;
         dll_q   <= 1'b0;
         done_q  <= 1'b0;
         warn_q  <= 1'b0;
         freq_q  <= 2'd0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  pwr_q  <= 1'b0;
                  dll_q  <= 1'b0;
                  err_q  <= ERR_NONE;
                  warn_q <= 1'b0;
                  rate_q <= rate_hz;
                  if (req_on) state_q <= ST_SETTLE;
                  else        done_q  <= 1'b1;
               end
            end
            ST_SETTLE: begin
               warn_q <= warn_c;
               if (tmr_exp) begin
                  pwr_q   <= 1'b1;
                  state_q <= ST_CAL_WAIT;
               end
            end
            ST_CAL_WAIT: begin
               if (cal_done_i) begin
                  freq_q  <= band_c;
                  state_q <= ST_DLL_ON;
               end else if (tmr_exp) begin
                  err_q   <= ERR_CAL_TMO;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_DLL_ON: begin
               dll_q <= 1'b1;
               if (rate_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_LOCK_WAIT;
               end
            end
            ST_LOCK_WAIT: begin
               if (dll_ready_i) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (tmr_exp) begin
                  err_q   <= ERR_LOCK_TMO;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign pwr_up_o    = pwr_q;
   assign dll_en_o    = dll_q;
   assign freq_sel_o  = freq_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign rate_warn_o = warn_q;

   // R6: the DLL is never enabled on an unpowered front end
   p_dll_needs_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dll_en_o |-> pwr_up_o);

   // R6: the band is already settled when the DLL is switched on
   p_freq_before_dll_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dll_en_o) |-> $stable(freq_sel_o));

   // R3: power-up only rises on leaving the settle wait
   p_pwr_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_up_o) |-> $past(state_q == ST_SETTLE));

   // R4: an error can only exist after power-up was raised
   p_err_with_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o != 2'd0) |-> pwr_up_o);

   // R7: a zero rate ends together with the DLL enable
   p_zero_rate_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dll_en_o) && (rate_q == '0)) |-> done_o);

   // R12: completion is reported only once the block is idle again
   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
   localparam int CYC = 4;
   localparam int SET = 3;
   localparam int CAL = 50;
   localparam int DLL = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_on = 1'b0;
   logic [31:0] rate_hz = '0;
   logic        cal_done_i = 1'b0;
   logic        dll_ready_i = 1'b0;
   logic        pwr_up_o, dll_en_o, busy_o, done_o, rate_warn_o;
   logic [1:0]  freq_sel_o, err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   phy_pwr_seq #(
      .CYC_PER_US(CYC),
      .RATE_W    (32),
      .SETTLE_US (SET),
      .CAL_TMO_US(CAL),
      .DLL_TMO_US(DLL)
   ) u_phy_pwr_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_on     (req_on),
      .rate_hz    (rate_hz),
      .cal_done_i (cal_done_i),
      .dll_ready_i(dll_ready_i),
      .pwr_up_o   (pwr_up_o),
      .dll_en_o   (dll_en_o),
      .freq_sel_o (freq_sel_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .err_o      (err_o),
      .rate_warn_o(rate_warn_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_band(input longint r);
      if (r == 0)                 return 2'd0;
      else if (r < 75_000_000)    return 2'd1;
      else if (r < 125_000_000)   return 2'd2;
      else if (r < 175_000_000)   return 2'd3;
      else                        return 2'd0;
   endfunction

   function automatic bit exp_warn(input longint r);
      longint nom;
      longint d;
      case (exp_band(r))
         2'd1:    nom = 50_000_000;
         2'd2:    nom = 100_000_000;
         2'd3:    nom = 150_000_000;
         default: nom = 200_000_000;
      endcase
      d = (r > nom) ? r - nom : nom - r;
      return ((r > 50_000_000) && (d > 15_000_000)) || (r > 200_000_000);
   endfunction

   // cal_at / dll_at: delay in cycles before the status input rises, 0 = never
   task automatic run_on(input logic [31:0] r, input int cal_at, input int dll_at, input bit poke);
      int cnt;
      int k;
      int dll_k;
      bit saw_dll;
      bit cal_seen;
      logic [1:0] exp_err;
      @(negedge clk);
      req_valid = 1'b1; req_on = 1'b1; rate_hz = r;
      @(negedge clk);
      req_valid = 1'b0; rate_hz = $urandom;  // R11: later changes must not matter
      chk(!pwr_up_o && !dll_en_o && busy_o, "R2 controls low after accept", {pwr_up_o, dll_en_o, busy_o}, 3'b001);
      cnt = 0;
      while (!pwr_up_o && cnt < 1000) begin
         @(negedge clk);
         cnt++;
         if (poke && cnt == 2) begin
            req_valid = 1'b1; req_on = 1'b0; rate_hz = 32'd0;
         end
         if (poke && cnt == 3) begin
            req_valid = 1'b0;
         end
         if (poke && cnt == 5)
            chk(busy_o && !done_o && !pwr_up_o, "R10 busy request ignored", {busy_o, done_o}, 2'b10);
      end
      chk(cnt >= SET * CYC && cnt <= SET * CYC + 2, "R3 settle length", cnt, SET * CYC + 1);
      chk(rate_warn_o == exp_warn(r), "R9 rate warning", rate_warn_o, exp_warn(r));
      k = 0; dll_k = 0; saw_dll = 1'b0; cal_seen = 1'b0;
      while (!done_o && k < 3000) begin
         @(negedge clk);
         k++;
         if (cal_at != 0 && k == cal_at) cal_done_i = 1'b1;
         if (dll_en_o && !saw_dll) begin
            saw_dll = 1'b1;
            dll_k = k;
            chk(freq_sel_o == exp_band(r), "R5 band code", freq_sel_o, exp_band(r));
            chk(cal_seen, "R6 band after calibration", cal_seen, 1);
         end
         if (saw_dll && dll_at != 0 && k == dll_k + dll_at - 1) dll_ready_i = 1'b1;
         if (cal_done_i) cal_seen = 1'b1;
      end
      exp_err = (cal_at == 0) ? 2'd1 : ((r != 0 && dll_at == 0) ? 2'd2 : 2'd0);
      if (exp_err == 2'd1) begin
         chk(err_o == 2'd1, "R4 calibration timeout code", err_o, 1);
         chk(k >= CAL * CYC && k <= CAL * CYC + 2, "R4 calibration timeout time", k, CAL * CYC + 1);
         chk(pwr_up_o && !dll_en_o, "R4 outputs held", {pwr_up_o, dll_en_o}, 2'b10);
      end else if (exp_err == 2'd2) begin
         chk(err_o == 2'd2, "R8 lock timeout code", err_o, 2);
         chk(k - dll_k >= DLL * CYC && k - dll_k <= DLL * CYC + 3, "R8 lock timeout time", k - dll_k, DLL * CYC + 2);
      end else begin
         chk(err_o == 2'd0 && dll_en_o && pwr_up_o, "R6 clean finish", err_o, 0);
      end
      if (r == 0 && cal_at != 0)
         chk(saw_dll && dll_k == k, "R7 zero rate finishes with DLL enable", k - dll_k, 0);
      @(negedge clk);
      chk(!done_o && err_o == exp_err, "R12 one-cycle done, sticky error", {done_o, err_o}, {1'b0, exp_err});
      chk(rate_warn_o == exp_warn(r), "R11 latched rate drives warning", rate_warn_o, exp_warn(r));
      cal_done_i = 1'b0; dll_ready_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_off();
      @(negedge clk);
      req_valid = 1'b1; req_on = 1'b0; rate_hz = 32'd180_000_000;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!pwr_up_o && !dll_en_o && done_o && !busy_o, "R2 power-off completes",
          {pwr_up_o, dll_en_o, done_o, busy_o}, 4'b0010);
      chk(err_o == 2'd0 && !rate_warn_o, "R12 error cleared by new request", {err_o, rate_warn_o}, 0);
      @(negedge clk);
      chk(!done_o, "R12 done lasts one cycle", done_o, 0);
   endtask

   initial begin
      automatic logic [31:0] corner[14] = '{32'd0, 32'd1, 32'd50_000_000, 32'd65_000_000,
         32'd65_000_001, 32'd74_999_999, 32'd75_000_000, 32'd100_000_000, 32'd124_999_999,
         32'd125_000_000, 32'd175_000_000, 32'd185_000_000, 32'd200_000_000, 32'd200_000_001};
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!pwr_up_o && !dll_en_o && !done_o && !busy_o && !rate_warn_o && freq_sel_o == 2'd0 && err_o == 2'd0,
          "R1 reset state", {pwr_up_o, dll_en_o, done_o, busy_o, rate_warn_o, freq_sel_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && !pwr_up_o, "R1 idle after reset release", busy_o, 0);
      foreach (corner[i]) run_on(corner[i], 3 + i, 5 + i, (i % 3) == 0);
      run_off();
      run_on(32'd100_000_000, 0, 5, 1'b0);     // calibration never completes
      run_off();
      run_on(32'd150_000_000, 4, 0, 1'b0);     // DLL never locks
      run_on(32'd0, 7, 0, 1'b0);               // zero rate: no lock wait
      run_off();
      for (int i = 0; i < 20; i++) begin
         automatic logic [31:0] r = $urandom_range(260_000_000, 0);
         run_on(r, $urandom_range(150, 1), $urandom_range(300, 1), ($urandom_range(1, 0) == 1));
      end
      run_off();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150_000; c++) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150_000, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule